// File: doc/BRIEF.md
# Failsafe watchdog supervisor

This block supervises a processor from a free-running clock. It takes two supply comparator flags and an active-low clear strobe from the software. It drives three active-low outputs: a timeout warning, a system reset and a data-save signal.

After the supply comes up, the block holds reset for one timeout period. It then expects a clear strobe within every timeout period. If a period passes without a clear, the warning output becomes a square wave that starts with a low phase. If the first low phase also passes unanswered, reset is asserted. A supply drop below the low threshold overrides all timer state at once. From then on, clears are refused until a complete new power-up sequence has finished.

The timeout length and the minimum clear pulse width are parameters counted in clock cycles. Tying the warning output back to the clear input turns the block into a plain supply monitor.

Top module: `wdog_supervisor`

## Requirements
- R1: While rst_ni is low, warn_no is high, rst_no is low and save_no is low.
- R2: Take the rising edge on which supply_ok_i is first sampled high, with supply_low_i low. Then rst_no and save_no rise exactly TIMEOUT_CYCLES edges later, and warn_no is high at that point.
- R3: A clear on clr_ni has no effect while the supply is down or the power-on delay is running. The delay length is unchanged by any clear.
- R4: clr_ni passes through a SYNC_STAGES-deep synchroniser and then a width filter. The synchronised level must stay low for MIN_PULSE consecutive cycles to count as one clear, and a held-low level counts only once. A qualified clear changes the outputs on the (MIN_PULSE+2)-th rising edge, counting the first edge that samples clr_ni low. A shorter low pulse is ignored.
- R5: While running, a qualified clear restarts the timeout count from zero. Clears spaced closer than TIMEOUT_CYCLES keep warn_no high indefinitely.
- R6: When TIMEOUT_CYCLES cycles pass after the last restart with no clear, warn_no goes low. It then toggles every TIMEOUT_CYCLES cycles, a square wave of period 2*TIMEOUT_CYCLES that starts low.
- R7: At the end of the first low phase of warn_no with no clear, rst_no goes low on the same edge that warn_no returns high. rst_no stays low through later toggles until a qualified clear arrives.
- R8: A qualified clear during the square wave or during escalated reset returns warn_no and rst_no high and restarts the timer.
- R9: While supply_low_i is high, rst_no and save_no are low and warn_no is high, combinationally and regardless of timer state.
- R10: After a brownout, clears are ignored, and save_no and rst_no stay low until supply_ok_i is seen and a full power-on delay has completed. save_no only ever falls while supply_low_i is high.
- R11: With warn_no tied to clr_ni, rst_no is never asserted after power-up. Each warn_no low pulse lasts MIN_PULSE+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above the upper threshold |
| supply_low_i | input | 1 | Supply below the lower threshold (brownout) |
| clr_ni | input | 1 | Active-low watchdog clear strobe, asynchronous |
| warn_no | output | 1 | Active-low timeout warning square wave |
| rst_no | output | 1 | Active-low system reset |
| save_no | output | 1 | Active-low data-save request |

## Verification
The bench targets four cases:

- **Clear latency.** A clear pulse one cycle short of the filter width must do nothing. A design that counted it would restart the timer early, and the next warning would arrive late.
- **Escalation edge.** A design that escalated one phase late would leave reset high through the first toggle. One that escalated early would pull reset while warning is still low.
- **Brownout.** The bench checks the brownout override in the same cycle it is applied, then sends clears during the outage and the following delay. A design that accepted those clears would release reset or save before the delay ends.
- **Loopback.** With the warning output fed back to the clear input, the block must never escalate, and each warning low pulse must be exactly the filter latency long.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_POR  = 2'd1,
    ST_RUN  = 2'd2
  } sup_state_e;

  typedef enum logic [1:0] {
    PH_ARMED     = 2'd0,
    PH_FIRST_LOW = 2'd1,
    PH_ESCALATED = 2'd2
  } warn_phase_e;
endpackage

// File: rtl/wdog_clr_filter.sv
module wdog_clr_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic clr_evt_o
);
  localparam int LW = $clog2(MIN_PULSE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LW-1:0]          low_q;
  logic                   clr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], clr_ni};
  end

  assign clr_s = sync_q[SYNC_STAGES-1];

  // saturating low-run counter: one event per low period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_q <= '0;
    else if (clr_s)                    low_q <= '0;
    else if (low_q != LW'(MIN_PULSE))  low_q <= low_q + 1'b1;
  end

  assign clr_evt_o = !clr_s && (low_q == LW'(MIN_PULSE - 1));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == CW'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i || expire_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic supply_low_i,
  input  logic clr_evt_i,
  input  logic expire_i,
  output logic restart_o,
  output logic warn_q_o,
  output logic rst_q_o,
  output logic save_q_o
);
  sup_state_e  state_q;
  warn_phase_e phase_q;

  assign restart_o = supply_low_i || (state_q == ST_DOWN) ||
                     ((state_q == ST_RUN) && clr_evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_DOWN;
      phase_q  <= PH_ARMED;
      warn_q_o <= 1'b1;
      rst_q_o  <= 1'b0;
      save_q_o <= 1'b0;
    end else if (supply_low_i) begin
      state_q  <= ST_DOWN;
      phase_q  <= PH_ARMED;
      warn_q_o <= 1'b1;
      rst_q_o  <= 1'b0;
      save_q_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DOWN: if (supply_ok_i) state_q <= ST_POR;
        ST_POR: if (expire_i) begin
          state_q  <= ST_RUN;
          phase_q  <= PH_ARMED;
          warn_q_o <= 1'b1;
          rst_q_o  <= 1'b1;
          save_q_o <= 1'b1;
        end
        ST_RUN: begin
          if (clr_evt_i) begin
            phase_q  <= PH_ARMED;
            warn_q_o <= 1'b1;
            rst_q_o  <= 1'b1;
          end else if (expire_i) begin
            unique case (phase_q)
              PH_ARMED: begin
                warn_q_o <= 1'b0;
                phase_q  <= PH_FIRST_LOW;
              end
              PH_FIRST_LOW: begin
                warn_q_o <= 1'b1;
                rst_q_o  <= 1'b0;
                phase_q  <= PH_ESCALATED;
              end
              default: warn_q_o <= !warn_q_o;
            endcase
          end
        end
        default: state_q <= ST_DOWN;
      endcase
    end
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int MIN_PULSE      = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic supply_low_i,
  input  logic clr_ni,
  output logic warn_no,
  output logic rst_no,
  output logic save_no
);
  logic clr_evt, expire, restart;
  logic warn_q, rst_q, save_q;

  wdog_clr_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_PULSE  (MIN_PULSE)
  ) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_ni),
    .clr_evt_o(clr_evt)
  );

  wdog_timer #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .expire_o (expire)
  );

  wdog_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .supply_low_i(supply_low_i),
    .clr_evt_i   (clr_evt),
    .expire_i    (expire),
    .restart_o   (restart),
    .warn_q_o    (warn_q),
    .rst_q_o     (rst_q),
    .save_q_o    (save_q)
  );

  // brownout override is combinational
  assign warn_no = warn_q || supply_low_i;
  assign rst_no  = rst_q && !supply_low_i;
  assign save_no = save_q && !supply_low_i;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_low_i,
  input logic warn_no,
  input logic rst_no,
  input logic save_no
);
  assert_brownout_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |-> (!rst_no && !save_no && warn_no));

  assert_release_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (warn_no && save_no));

  assert_escalate_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_no) && !supply_low_i) |-> (warn_no && $past(!warn_no)));

  assert_warn_only_powered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warn_no |-> save_no);

  assert_save_holds_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !save_no |-> !rst_no);

  assert_save_falls_on_brownout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(save_no) |-> supply_low_i);
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_low_i(supply_low_i),
  .warn_no     (warn_no),
  .rst_no      (rst_no),
  .save_no     (save_no)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int T    = 16;
  localparam int MINP = 3;

  logic clk = 0, rst_ni = 0;
  logic supply_ok = 0, supply_low = 0, clr_drv = 1, loop_en = 0;
  logic clr_ni, warn_no, rst_no, save_no;
  int n_checks = 0, n_errs = 0;
  bit done = 0;

  assign clr_ni = loop_en ? warn_no : clr_drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_supervisor #(.TIMEOUT_CYCLES(T), .MIN_PULSE(MINP), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .supply_low_i(supply_low),
    .clr_ni(clr_ni), .warn_no(warn_no), .rst_no(rst_no), .save_no(save_no));

  // behavioural reference model
  int m_mode, m_cnt, m_phase, m_low;
  bit m_warn, m_rst, m_save, m_s1, m_s2;
  always @(posedge clk or negedge rst_ni) begin
    bit evt, exp_t;
    if (!rst_ni) begin
      m_mode = 0; m_cnt = 0; m_phase = 0; m_low = 0;
      m_warn = 1; m_rst = 0; m_save = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      evt   = (m_s2 == 0) && (m_low == MINP - 1);
      exp_t = (m_cnt == T - 1);
      if (supply_low) begin
        m_mode = 0; m_cnt = 0; m_phase = 0; m_warn = 1; m_rst = 0; m_save = 0;
      end else if (m_mode == 0) begin
        m_cnt = 0;
        if (supply_ok) m_mode = 1;
      end else if (m_mode == 1) begin
        if (exp_t) begin
          m_mode = 2; m_cnt = 0; m_phase = 0; m_warn = 1; m_rst = 1; m_save = 1;
        end else m_cnt++;
      end else begin
        if (evt) begin
          m_cnt = 0; m_phase = 0; m_warn = 1; m_rst = 1;
        end else if (exp_t) begin
          m_cnt = 0;
          if (m_phase == 0) begin m_warn = 0; m_phase = 1; end
          else if (m_phase == 1) begin m_warn = 1; m_rst = 0; m_phase = 2; end
          else m_warn = !m_warn;
        end else m_cnt++;
      end
      if (m_s2) m_low = 0; else if (m_low < MINP) m_low++;
      m_s2 = m_s1; m_s1 = clr_ni;
    end
  end

  function automatic string tag();
    if (supply_low)        return "R9";
    if (m_mode == 0)       return "R10";
    if (m_mode == 1)       return "R2";
    if (m_phase == 0)      return "R5";
    if (m_phase == 1)      return "R6";
    return "R7";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    check(tag(), "lockstep warn_no", warn_no, m_warn | supply_low);
    check(tag(), "lockstep rst_no",  rst_no,  m_rst & !supply_low);
    check(tag(), "lockstep save_no", save_no, m_save & !supply_low);
  end

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired: actual hang expected completion");
    finish_run();
  end

  initial begin
    int n, w;
    bit bad;
    repeat (3) nxt();
    check("R1", "reset warn_no", warn_no, 1);
    check("R1", "reset rst_no", rst_no, 0);
    check("R1", "reset save_no", save_no, 0);
    #1 rst_ni = 1;
    repeat (2) nxt();

    // R3: clear while down
    #1 clr_drv = 0;
    repeat (MINP + 2) nxt();
    #1 clr_drv = 1;
    repeat (3) nxt();
    check("R3", "clear while down rst_no", rst_no, 0);

    // R2 power-on delay, R3 clear during delay
    #1 supply_ok = 1;
    n = 0;
    while (n < 4 * T) begin
      nxt(); n++;
      if (rst_no) break;
      if (n == 3) #1 clr_drv = 0;
      if (n == 3 + MINP + 2) #1 clr_drv = 1;
    end
    check("R2", "por delay edges (R3 clear ignored)", n, T + 1);
    check("R2", "save_no after por", save_no, 1);
    check("R2", "warn_no after por", warn_no, 1);

    // R5 periodic clears
    bad = 0;
    for (int r = 0; r < 6; r++) begin
      #1 clr_drv = 0;
      repeat (MINP + 1) begin nxt(); if (!warn_no) bad = 1; end
      #1 clr_drv = 1;
      repeat (T / 2 - MINP - 1) begin nxt(); if (!warn_no) bad = 1; end
    end
    check("R5", "warn low under periodic clears", bad, 0);

    // R4 latency + R6 first warning
    #1 clr_drv = 0;
    n = 0;
    while (warn_no && n < 4 * T) begin
      nxt(); n++;
      if (n == MINP + 1) #1 clr_drv = 1;
    end
    check("R6", "edges clear->warn low", n, T + MINP + 2);
    check("R4", "clear latency folded into warn timing", n - T, MINP + 2);
    bad = 0; n = 0;
    while (!warn_no && n < 4 * T) begin nxt(); n++; if (!warn_no && !rst_no) bad = 1; end
    check("R6", "first low phase length", n, T);
    check("R7", "rst_no low during first low phase", bad, 0);
    check("R7", "rst_no after first low phase", rst_no, 0);
    n = 0;
    while (warn_no && n < 4 * T) begin nxt(); n++; end
    check("R6", "square wave high phase", n, T);
    check("R7", "rst_no stays low", rst_no, 0);

    // R8 clear while escalated
    #1 clr_drv = 0;
    n = 0;
    while (!rst_no && n < 4 * T) begin
      nxt(); n++;
      if (n == MINP + 1) #1 clr_drv = 1;
    end
    check("R8", "clear->rst release edges", n, MINP + 2);
    check("R8", "warn_no after clear", warn_no, 1);

    // R4 short glitch ignored
    n = 0;
    #1 clr_drv = 0;
    repeat (MINP - 1) begin nxt(); n++; end
    #1 clr_drv = 1;
    while (warn_no && n < 4 * T) begin nxt(); n++; end
    check("R4", "short glitch did not restart", n, T);

    // R9 brownout override
    nxt();
    #1 begin supply_low = 1; supply_ok = 0; end
    #1;
    check("R9", "brownout rst_no", rst_no, 0);
    check("R9", "brownout save_no", save_no, 0);
    check("R9", "brownout warn_no", warn_no, 1);

    // R10 clears ignored after brownout
    nxt();
    #1 clr_drv = 0;
    repeat (MINP + 2) nxt();
    #1 clr_drv = 1;
    #1;
    check("R10", "clear in brownout rst_no", rst_no, 0);
    check("R10", "clear in brownout save_no", save_no, 0);
    #1 supply_low = 0;
    repeat (T + 4) nxt();
    check("R10", "no supply_ok rst_no", rst_no, 0);
    check("R10", "no supply_ok save_no", save_no, 0);
    #1 supply_ok = 1;
    n = 0;
    while (n < 4 * T) begin
      nxt(); n++;
      if (save_no) break;
      if (n == 2) #1 clr_drv = 0;
      if (n == 2 + MINP + 2) #1 clr_drv = 1;
    end
    check("R10", "save release after new por", n, T + 1);
    check("R10", "rst_no with save release", rst_no, 1);

    // R11 loopback supply monitor
    #1 loop_en = 1;
    n = 0;
    while (warn_no && n < 4 * T) begin nxt(); n++; end
    w = 1;
    forever begin nxt(); if (!warn_no) w++; else break; end
    check("R11", "loopback warn low width", w, MINP + 2);
    bad = 0;
    repeat (5 * T) begin nxt(); if (!rst_no) bad = 1; end
    check("R11", "loopback never resets", bad, 0);
    #1 loop_en = 0;
    repeat (2) nxt();
    finish_run();
  end
endmodule